// File: doc/BRIEF.md
# Display PHY PLL Bring-Up Sequencer

This block owns the three configuration words that steer a display PHY's PLL and walks them through the ordered bring-up the PLL needs. Software, or a higher-level controller, presents the operating point as plain values: the configuration clock in MHz, a high-speed range code, the multiplier M, the divider N, and the VCO and proportional charge-pump codes. It then raises `start_i` for one cycle. The sequencer captures those values on that edge. It first selects internal clock generation and holds that choice for a settling time. It then pulses the shadow-clear bit, drops it again while generation stays selected, and writes all three words. At the same time it enables the reference clock. After a reference settle time it pulses update-PLL for a fixed minimum width, and it signals completion with a one-cycle `done_o`.

The block is clocked from the PHY reference clock, so every wait is a whole number of that clock's cycles, set by a parameter. A `power_off_i` pulse aborts any step at once. It zeroes all three words, drops the reference enable and returns the sequencer to rest.

The states are ST_IDLE, ST_CLKSEL, ST_SHADOW_ON, ST_SHADOW_OFF, ST_LOAD, ST_REF_WAIT, ST_UPD_ON, ST_UPD_OFF and ST_DONE. The transitions are:
- ST_IDLE to ST_CLKSEL on an accepted start.
- ST_CLKSEL to ST_SHADOW_ON after SEL_HOLD cycles.
- ST_SHADOW_ON to ST_SHADOW_OFF after SHADOW_W cycles.
- ST_SHADOW_OFF to ST_LOAD and ST_LOAD to ST_REF_WAIT, one cycle each.
- ST_REF_WAIT to ST_UPD_ON after REF_SETTLE cycles.
- ST_UPD_ON to ST_UPD_OFF after UPD_W cycles.
- ST_UPD_OFF to ST_DONE and ST_DONE to ST_IDLE, one cycle each.
- Any state to ST_IDLE on power-off.

Top module: `pll_seq_top`

## Requirements
- R1: After reset all three words are zero, and `ref_clk_en_o` and `done_o` are low.
- R2: An accepted start first clears the divider and bias words and drops the reference enable. It sets the control word to clock-select = 1 (internal generation, bits 7:6; 0 = stop, 2 = external) with every other bit 0, and holds that word for SEL_HOLD cycles.
- R3: Shadow-clear (control bit 18) then stays high for exactly SHADOW_W cycles with clock-select still 1. It falls for exactly one cycle, with clock-select still 1, before the words are loaded. It is never high together with update-PLL (bit 17).
- R4: The loaded control word carries ((cfg_mhz_i − 17) × 4) mod 64 in bits 5:0, clock-select 1 in bits 7:6 and the high-speed range in bits 14:8. All other bits are 0, including external clock (bit 19).
- R5: The loaded divider word carries M − 2 in bits 9:0, N − 1 in bits 13:10, the VCO code in bits 19:14 and the proportional code in bits 25:20. The integral field (bits 31:26) is 0.
- R6: The loaded bias word is 0x41: gmp control 1 in bits 1:0 and charge-pump bias 0x10 in bits 8:2.
- R7: `ref_clk_en_o` rises with the load. Update-PLL rises exactly 1 + REF_SETTLE cycles later and is only ever high while the reference is enabled.
- R8: Update-PLL stays high for exactly UPD_W cycles. It is low for one cycle before `done_o`.
- R9: `done_o` is a one-cycle pulse. Afterwards the loaded words and the reference enable are held unchanged.
- R10: A start that arrives while a sequence runs, including in its done cycle, is ignored.
- R11: `power_off_i` at any point zeroes all three words and the reference enable on the next edge and returns to rest without a done pulse. It wins over a simultaneous start.
- R12: A start after a completed sequence runs the whole sequence again from the clock-select step.
- R13: Field inputs are sampled only on the accepted start edge. Changing them during the sequence does not alter the loaded words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to run the bring-up |
| power_off_i | input | 1 | Abort and clear all words |
| cfg_mhz_i | input | 8 | Configuration clock frequency in MHz |
| hs_range_i | input | 7 | High-speed frequency range code |
| m_val_i | input | 10 | PLL multiplier M |
| n_val_i | input | 5 | PLL input divider N (1 to 16) |
| vco_ctl_i | input | 6 | VCO range code |
| prop_ctl_i | input | 6 | Proportional charge-pump code |
| ctl_word_o | output | 32 | Control word (ranges, clock-select, update, shadow-clear) |
| div_word_o | output | 32 | Divider and loop-filter word |
| bias_word_o | output | 32 | Charge-pump bias word |
| ref_clk_en_o | output | 1 | Reference clock enable |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The situations hardest to reach from the ports are requests that land inside a running sequence. These are a power-off during the reference settle wait, a second start while shadow-clear is high, and a start in the done cycle itself. The stimulus counts clock edges from the edge that accepted the first start and places each pulse in the intended state. It changes the field inputs in the same cycle to expose any late capture. The scoreboard holds an ordered list of output snapshots with their expected durations, so a restarted or aborted sequence appears as a snapshot or a duration that does not match.

// File: rtl/pll_seq_pkg.sv
`timescale 1ns/1ps
package pll_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CLKSEL,
        ST_SHADOW_ON,
        ST_SHADOW_OFF,
        ST_LOAD,
        ST_REF_WAIT,
        ST_UPD_ON,
        ST_UPD_OFF,
        ST_DONE
    } seq_state_e;

    localparam int WORD_W      = 32;

    // control word layout
    localparam int CFGR_LSB    = 0;
    localparam int CFGR_W      = 6;
    localparam int SEL_LSB     = 6;
    localparam int HSR_LSB     = 8;
    localparam int HSR_W       = 7;
    localparam int UPD_BIT     = 17;
    localparam int SHCLR_BIT   = 18;
    localparam int EXTCLK_BIT  = 19;

    localparam logic [1:0] SEL_STOP = 2'd0;
    localparam logic [1:0] SEL_GEN  = 2'd1;
    localparam logic [1:0] SEL_EXT  = 2'd2;

    // divider word layout
    localparam int MUL_LSB     = 0;
    localparam int MUL_W       = 10;
    localparam int DIV_LSB     = 10;
    localparam int DIV_W       = 4;
    localparam int VCO_LSB     = 14;
    localparam int VCO_W       = 6;
    localparam int PROP_LSB    = 20;
    localparam int PROP_W      = 6;
    localparam int INTG_LSB    = 26;

    // bias word layout and fixed values
    localparam int GMP_LSB     = 0;
    localparam int CPB_LSB     = 2;
    localparam logic [1:0] GMP_VAL = 2'd1;
    localparam logic [6:0] CPB_VAL = 7'h10;

    localparam logic [7:0] CFGCLK_OFFS_MHZ = 8'd17;

    function automatic logic [WORD_W-1:0] mk_ctl(
        input logic [CFGR_W-1:0] cfgr,
        input logic [1:0]        sel,
        input logic [HSR_W-1:0]  hsr,
        input logic              upd,
        input logic              shclr
    );
        logic [WORD_W-1:0] w;
        w = '0;
        w[CFGR_LSB +: CFGR_W] = cfgr;
        w[SEL_LSB +: 2]       = sel;
        w[HSR_LSB +: HSR_W]   = hsr;
        w[UPD_BIT]            = upd;
        w[SHCLR_BIT]          = shclr;
        w[EXTCLK_BIT]         = 1'b0;
        return w;
    endfunction

endpackage

// File: rtl/pll_seq_capture.sv
`timescale 1ns/1ps
module pll_seq_capture
    import pll_seq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                capture,
    input  logic [7:0]          cfg_mhz,
    input  logic [HSR_W-1:0]    hs_range,
    input  logic [MUL_W-1:0]    m_val,
    input  logic [4:0]          n_val,
    input  logic [VCO_W-1:0]    vco_ctl,
    input  logic [PROP_W-1:0]   prop_ctl,
    output logic [WORD_W-1:0]   ctl_load,
    output logic [WORD_W-1:0]   div_load,
    output logic [WORD_W-1:0]   bias_load
);

    logic [CFGR_W-1:0] cfgr_q;
    logic [HSR_W-1:0]  hsr_q;
    logic [MUL_W-1:0]  mcode_q;
    logic [DIV_W-1:0]  ncode_q;
    logic [VCO_W-1:0]  vco_q;
    logic [PROP_W-1:0] prop_q;

    logic [7:0] mhz_offs;
    logic [4:0] n_minus;

    assign mhz_offs = cfg_mhz - CFGCLK_OFFS_MHZ;
    assign n_minus  = n_val - 5'd1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfgr_q  <= '0;
            hsr_q   <= '0;
            mcode_q <= '0;
            ncode_q <= '0;
            vco_q   <= '0;
            prop_q  <= '0;
        end else if (capture) begin
            cfgr_q  <= {mhz_offs[3:0], 2'b00};
            hsr_q   <= hs_range;
            mcode_q <= m_val - 10'd2;
            ncode_q <= n_minus[DIV_W-1:0];
            vco_q   <= vco_ctl;
            prop_q  <= prop_ctl;
        end
    end

    always_comb begin
        ctl_load = mk_ctl(cfgr_q, SEL_GEN, hsr_q, 1'b0, 1'b0);
        div_load = '0;
        div_load[MUL_LSB +: MUL_W]   = mcode_q;
        div_load[DIV_LSB +: DIV_W]   = ncode_q;
        div_load[VCO_LSB +: VCO_W]   = vco_q;
        div_load[PROP_LSB +: PROP_W] = prop_q;
        div_load[WORD_W-1:INTG_LSB]  = '0;
        bias_load = '0;
        bias_load[GMP_LSB +: 2] = GMP_VAL;
        bias_load[CPB_LSB +: 7] = CPB_VAL;
    end

endmodule

// File: rtl/pll_seq_timer.sv
`timescale 1ns/1ps
module pll_seq_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/pll_seq_fsm.sv
`timescale 1ns/1ps
module pll_seq_fsm
    import pll_seq_pkg::*;
#(
    parameter int SEL_HOLD   = 3,
    parameter int SHADOW_W   = 2,
    parameter int REF_SETTLE = 10,
    parameter int UPD_W      = 4,
    parameter int CW         = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              power_off_i,
    input  logic [WORD_W-1:0] ctl_load,
    input  logic [WORD_W-1:0] div_load,
    input  logic [WORD_W-1:0] bias_load,
    input  logic              tmr_expired,
    output logic              tmr_load,
    output logic [CW-1:0]     tmr_val,
    output logic              capture_o,
    output logic [WORD_W-1:0] ctl_o,
    output logic [WORD_W-1:0] div_o,
    output logic [WORD_W-1:0] bias_o,
    output logic              ref_en_o,
    output logic              done_o
);

    localparam logic [WORD_W-1:0] GEN_WORD   = mk_ctl('0, SEL_GEN, '0, 1'b0, 1'b0);
    localparam logic [WORD_W-1:0] SHCLR_WORD = mk_ctl('0, SEL_GEN, '0, 1'b0, 1'b1);
    localparam logic [WORD_W-1:0] UPD_MASK   = WORD_W'(1) << UPD_BIT;

    seq_state_e state_q, state_d;

    assign capture_o = (state_q == ST_IDLE) && start_i && !power_off_i;

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (power_off_i) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:       if (start_i)     state_d = ST_CLKSEL;
                ST_CLKSEL:     if (tmr_expired) state_d = ST_SHADOW_ON;
                ST_SHADOW_ON:  if (tmr_expired) state_d = ST_SHADOW_OFF;
                ST_SHADOW_OFF:                  state_d = ST_LOAD;
                ST_LOAD:                        state_d = ST_REF_WAIT;
                ST_REF_WAIT:   if (tmr_expired) state_d = ST_UPD_ON;
                ST_UPD_ON:     if (tmr_expired) state_d = ST_UPD_OFF;
                ST_UPD_OFF:                     state_d = ST_DONE;
                ST_DONE:                        state_d = ST_IDLE;
                default:                        state_d = ST_IDLE;
            endcase
        end
    end

    // wait length loaded on entry to each timed state
    always_comb begin
        tmr_load = (state_d != state_q);
        unique case (state_d)
            ST_CLKSEL:    tmr_val = CW'(SEL_HOLD - 1);
            ST_SHADOW_ON: tmr_val = CW'(SHADOW_W - 1);
            ST_REF_WAIT:  tmr_val = CW'(REF_SETTLE - 1);
            ST_UPD_ON:    tmr_val = CW'(UPD_W - 1);
            default:      tmr_val = '0;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output register, aligned with the state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_o    <= '0;
            div_o    <= '0;
            bias_o   <= '0;
            ref_en_o <= 1'b0;
            done_o   <= 1'b0;
        end else if (power_off_i) begin
            ctl_o    <= '0;
            div_o    <= '0;
            bias_o   <= '0;
            ref_en_o <= 1'b0;
            done_o   <= 1'b0;
        end else begin
            done_o <= (state_d == ST_DONE);
            unique case (state_d)
                ST_IDLE: ;
                ST_CLKSEL: begin
                    ctl_o    <= GEN_WORD;
                    div_o    <= '0;
                    bias_o   <= '0;
                    ref_en_o <= 1'b0;
                end
                ST_SHADOW_ON:  ctl_o <= SHCLR_WORD;
                ST_SHADOW_OFF: ctl_o <= GEN_WORD;
                ST_LOAD, ST_REF_WAIT: begin
                    ctl_o    <= ctl_load;
                    div_o    <= div_load;
                    bias_o   <= bias_load;
                    ref_en_o <= 1'b1;
                end
                ST_UPD_ON:           ctl_o <= ctl_load | UPD_MASK;
                ST_UPD_OFF, ST_DONE: ctl_o <= ctl_load;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/pll_seq_top.sv
`timescale 1ns/1ps
module pll_seq_top
    import pll_seq_pkg::*;
#(
    parameter int SEL_HOLD   = 3,
    parameter int SHADOW_W   = 2,
    parameter int REF_SETTLE = 10,
    parameter int UPD_W      = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic        power_off_i,
    input  logic [7:0]  cfg_mhz_i,
    input  logic [6:0]  hs_range_i,
    input  logic [9:0]  m_val_i,
    input  logic [4:0]  n_val_i,
    input  logic [5:0]  vco_ctl_i,
    input  logic [5:0]  prop_ctl_i,
    output logic [31:0] ctl_word_o,
    output logic [31:0] div_word_o,
    output logic [31:0] bias_word_o,
    output logic        ref_clk_en_o,
    output logic        done_o
);

    localparam int MAX_AB  = (SEL_HOLD > SHADOW_W) ? SEL_HOLD : SHADOW_W;
    localparam int MAX_CD  = (REF_SETTLE > UPD_W) ? REF_SETTLE : UPD_W;
    localparam int MAX_LEN = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int CW      = $clog2(MAX_LEN + 1);

    logic [WORD_W-1:0] ctl_load, div_load, bias_load;
    logic              capture;
    logic              tmr_load, tmr_expired;
    logic [CW-1:0]     tmr_val;

    pll_seq_capture u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (capture),
        .cfg_mhz   (cfg_mhz_i),
        .hs_range  (hs_range_i),
        .m_val     (m_val_i),
        .n_val     (n_val_i),
        .vco_ctl   (vco_ctl_i),
        .prop_ctl  (prop_ctl_i),
        .ctl_load  (ctl_load),
        .div_load  (div_load),
        .bias_load (bias_load)
    );

    pll_seq_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    pll_seq_fsm #(
        .SEL_HOLD   (SEL_HOLD),
        .SHADOW_W   (SHADOW_W),
        .REF_SETTLE (REF_SETTLE),
        .UPD_W      (UPD_W),
        .CW         (CW)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .power_off_i (power_off_i),
        .ctl_load    (ctl_load),
        .div_load    (div_load),
        .bias_load   (bias_load),
        .tmr_expired (tmr_expired),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .capture_o   (capture),
        .ctl_o       (ctl_word_o),
        .div_o       (div_word_o),
        .bias_o      (bias_word_o),
        .ref_en_o    (ref_clk_en_o),
        .done_o      (done_o)
    );

endmodule

// File: rtl/pll_seq_chk.sv
`timescale 1ns/1ps
module pll_seq_chk #(
    parameter int UPD_W = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic        power_off_i,
    input logic [31:0] ctl_word_o,
    input logic [31:0] div_word_o,
    input logic [31:0] bias_word_o,
    input logic        ref_clk_en_o,
    input logic        done_o
);

    logic [15:0] upd_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              upd_run <= '0;
        else if (ctl_word_o[17]) upd_run <= upd_run + 16'd1;
        else                     upd_run <= '0;
    end

    assert_shadow_gen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_word_o[18] |-> ctl_word_o[7:6] == 2'b01);

    assert_shadow_upd_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctl_word_o[18] && ctl_word_o[17]));

    assert_upd_needs_ref_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_word_o[17] |-> ref_clk_en_o);

    assert_bias_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ref_clk_en_o |-> bias_word_o == 32'h41);

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_poweroff_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        power_off_i |=> (ctl_word_o == '0 && div_word_o == '0 &&
                         bias_word_o == '0 && !ref_clk_en_o && !done_o));

    assert_upd_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ctl_word_o[17]) && ctl_word_o != '0) |-> upd_run >= 16'(UPD_W));

    assert_done_after_upd_R8: assert property (@(posedge clk) disable iff (!rst_n || power_off_i)
        ($fell(ctl_word_o[17]) && ctl_word_o[7:6] == 2'b01) |=> done_o);

endmodule

bind pll_seq_top pll_seq_chk #(.UPD_W(UPD_W)) u_pll_seq_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .power_off_i  (power_off_i),
    .ctl_word_o   (ctl_word_o),
    .div_word_o   (div_word_o),
    .bias_word_o  (bias_word_o),
    .ref_clk_en_o (ref_clk_en_o),
    .done_o       (done_o)
);

// File: tb/tb_pll_seq_top.sv
`timescale 1ns/1ps
module tb_pll_seq_top;

    localparam int SEL_HOLD   = 3;
    localparam int SHADOW_W   = 2;
    localparam int REF_SETTLE = 10;
    localparam int UPD_W      = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        power_off_i = 1'b0;
    logic [7:0]  cfg_mhz_i = '0;
    logic [6:0]  hs_range_i = '0;
    logic [9:0]  m_val_i = '0;
    logic [4:0]  n_val_i = '0;
    logic [5:0]  vco_ctl_i = '0;
    logic [5:0]  prop_ctl_i = '0;
    logic [31:0] ctl_word_o, div_word_o, bias_word_o;
    logic        ref_clk_en_o, done_o;

    always #2.5 clk = ~clk;

    pll_seq_top #(
        .SEL_HOLD(SEL_HOLD), .SHADOW_W(SHADOW_W),
        .REF_SETTLE(REF_SETTLE), .UPD_W(UPD_W)
    ) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .power_off_i(power_off_i),
        .cfg_mhz_i(cfg_mhz_i), .hs_range_i(hs_range_i), .m_val_i(m_val_i),
        .n_val_i(n_val_i), .vco_ctl_i(vco_ctl_i), .prop_ctl_i(prop_ctl_i),
        .ctl_word_o(ctl_word_o), .div_word_o(div_word_o), .bias_word_o(bias_word_o),
        .ref_clk_en_o(ref_clk_en_o), .done_o(done_o)
    );

    typedef struct {
        logic [97:0] snap;
        int          len;
        string       tag;
    } item_t;

    item_t       exp_q[$];
    item_t       it;
    int          vectors = 0;
    int          fails = 0;
    bit          mon_on = 1'b0;
    bit          finished = 1'b0;
    logic [97:0] cur = '0;
    logic [97:0] obs;
    int          cur_len = 0;
    string       cur_tag = "";
    int          run = 0;

    function automatic logic [97:0] mk_snap(input logic [31:0] c, d, b,
                                            input logic r, dn);
        return {c, d, b, r, dn};
    endfunction

    task automatic check_vec(input bit ok, input string tag,
                             input logic [97:0] got, input logic [97:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic check_int(input bit ok, input string tag, input int got, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    // monitor: pop one expected snapshot per observed output change
    always @(negedge clk) begin
        if (mon_on) begin
            obs = mk_snap(ctl_word_o, div_word_o, bias_word_o, ref_clk_en_o, done_o);
            if (obs !== cur) begin
                if (cur_len != 0)
                    check_int(run == cur_len, {cur_tag, " duration"}, run, cur_len);
                if (exp_q.size() == 0) begin
                    check_vec(1'b0, "R10 unexpected change", obs, cur);
                end else begin
                    it = exp_q.pop_front();
                    check_vec(obs === it.snap, it.tag, obs, it.snap);
                    cur_len = it.len;
                    cur_tag = it.tag;
                end
                cur = obs;
                run = 1;
            end else begin
                run++;
            end
        end
    end

    // driver: push the expected snapshots, then stimulate
    task automatic run_seq(input int mhz, hs, m, n, vco, prop,
                           input bit poke_busy, input bit poke_done, input bit po_mid);
        logic [31:0] gen_w, sh_w, ld_w, dv_w, bs_w, up_w;
        gen_w = 32'h40;
        sh_w  = gen_w | (32'd1 << 18);
        ld_w  = 32'(((mhz - 17) * 4) % 64) | gen_w | (32'(hs) << 8);
        up_w  = ld_w | (32'd1 << 17);
        dv_w  = 32'(m - 2) | (32'(n - 1) << 10) | (32'(vco) << 14) | (32'(prop) << 20);
        bs_w  = 32'h1 | (32'h10 << 2);

        exp_q.push_back('{mk_snap(gen_w, 0, 0, 0, 0), SEL_HOLD, "R2 R12 clock-select step"});
        exp_q.push_back('{mk_snap(sh_w, 0, 0, 0, 0), SHADOW_W, "R3 shadow-clear high"});
        exp_q.push_back('{mk_snap(gen_w, 0, 0, 0, 0), 1, "R3 shadow-clear low"});
        if (po_mid) begin
            exp_q.push_back('{mk_snap(ld_w, dv_w, bs_w, 1, 0), 0, "R4 R5 R6 R13 load"});
            exp_q.push_back('{mk_snap(0, 0, 0, 0, 0), 0, "R11 power-off clear"});
        end else begin
            exp_q.push_back('{mk_snap(ld_w, dv_w, bs_w, 1, 0), 1 + REF_SETTLE,
                              "R4 R5 R6 R7 R13 load and settle"});
            exp_q.push_back('{mk_snap(up_w, dv_w, bs_w, 1, 0), UPD_W, "R8 update high"});
            exp_q.push_back('{mk_snap(ld_w, dv_w, bs_w, 1, 0), 1, "R8 update low"});
            exp_q.push_back('{mk_snap(ld_w, dv_w, bs_w, 1, 1), 1, "R9 done pulse"});
            exp_q.push_back('{mk_snap(ld_w, dv_w, bs_w, 1, 0), 0, "R9 words held"});
        end

        @(posedge clk); #1;
        cfg_mhz_i = 8'(mhz); hs_range_i = 7'(hs); m_val_i = 10'(m);
        n_val_i = 5'(n); vco_ctl_i = 6'(vco); prop_ctl_i = 6'(prop);
        start_i = 1'b1;
        @(posedge clk); #1;                 // accepting edge
        start_i = 1'b0;
        if (po_mid) begin
            repeat (8) @(posedge clk);
            #1 power_off_i = 1'b1;
            @(posedge clk); #1 power_off_i = 1'b0;
            repeat (8) @(posedge clk);
        end else if (poke_busy) begin
            repeat (3) @(posedge clk);
            #1 start_i = 1'b1;              // R10: lands in shadow-clear step
            cfg_mhz_i = 8'd30; hs_range_i = 7'h11; m_val_i = 10'd99;
            n_val_i = 5'd3; vco_ctl_i = 6'h2; prop_ctl_i = 6'h3;
            @(posedge clk); #1 start_i = 1'b0;
            repeat (30) @(posedge clk);
        end else if (poke_done) begin
            repeat (22) @(posedge clk);
            #1 start_i = 1'b1;              // R10: lands in the done cycle
            @(posedge clk); #1 start_i = 1'b0;
            repeat (10) @(posedge clk);
        end else begin
            repeat (32) @(posedge clk);
        end
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL R9 watchdog: got no completion, expected end of run");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        obs = mk_snap(ctl_word_o, div_word_o, bias_word_o, ref_clk_en_o, done_o);
        check_vec(obs === '0, "R1 reset state", obs, '0);
        cur = '0;
        mon_on = 1'b1;

        run_seq(24, 'h2a, 300, 5, 'h0f, 'h0d, 1'b1, 1'b0, 1'b0);
        run_seq(20, 'h35, 64, 1, 'h3f, 'h0e, 1'b0, 1'b1, 1'b0);
        run_seq(32, 'h49, 625, 16, 'h01, 'h0d, 1'b0, 1'b0, 1'b1);

        // R11: power-off and start together while idle
        @(posedge clk); #1 start_i = 1'b1; power_off_i = 1'b1;
        @(posedge clk); #1 start_i = 1'b0; power_off_i = 1'b0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        obs = mk_snap(ctl_word_o, div_word_o, bias_word_o, ref_clk_en_o, done_o);
        check_vec(obs === '0, "R11 start blocked by power-off", obs, '0);

        run_seq(17, 'h7f, 2, 16, 'h3f, 'h3f, 1'b0, 1'b0, 1'b0);

        repeat (4) @(posedge clk);
        check_int(exp_q.size() == 0, "R10 all expected snapshots seen", exp_q.size(), 0);
        finish_run();
    end

endmodule